// File: doc/BRIEF.md
# Conversion Start Trigger Selector

This block decides when a conversion sequencer is launched. One of several external trigger lines is picked by a selector field. The picked line is resynchronised into the local clock. A 2-bit edge mode then says which transition of that line counts as a start. When the edge mode is zero, hardware triggering is off and only the software start request can launch a sequence.

Every accepted start produces a single-cycle `start_pulse` and sets a sticky `started` flag, which software clears. The software request is a self-clearing bit. It is reported on `sw_pending` for the one cycle between its write and the pulse it causes.

When the selector changes, edge detection is blanked until the synchroniser and the edge history both hold the new source's level. The same blanking follows reset. Because of this, a level difference between the old and new source never produces a start.

Top module: `conv_trig_select`

## Requirements
- R1: After reset, `start_pulse`, `started` and `sw_pending` are 0. Edge detection is blanked for SYNC_STAGES+1 cycles, so a selected line that is already high at reset release produces no pulse.
- R2: Only the line `trig_in[trig_sel]` can cause a hardware start. Transitions on any other line have no effect on `start_pulse`.
- R3: A request on `sw_start_set` in the cycle before edge k, with `edge_mode` = 0, makes `sw_pending` read 1 after edge k. If `edge_mode` is still 0 in that cycle, `start_pulse` reads 1 after edge k+1 and `sw_pending` returns to 0. A request made while `edge_mode` is nonzero is dropped. A pending request is also dropped if `edge_mode` becomes nonzero before it fires.
- R4: `edge_mode` encodes the hardware start condition: 1 = rising edge, 2 = falling edge, 3 = either edge. Each matching transition of the selected line gives exactly one pulse, and a non-matching one gives none.
- R5: With `edge_mode` = 0, no transition on any trigger line produces a start.
- R6: A transition of the selected line set up before clock edge k makes `start_pulse` high only in the cycle after edge k+SYNC_STAGES, and low again after the following edge.
- R7: `started` becomes 1 together with every start pulse and stays 1 until `started_clr` is asserted. A start in the same cycle as a clear leaves `started` at 1.
- R8: A change of `trig_sel` blanks edge detection for SYNC_STAGES cycles while the history reloads from the new source. Switching from a low line to a high line produces no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| trig_in | input | NUM_SRC | External trigger lines, asynchronous |
| trig_sel | input | $clog2(NUM_SRC) | Index of the trigger line in use |
| edge_mode | input | 2 | 0 software only, 1 rising, 2 falling, 3 both |
| sw_start_set | input | 1 | Software start request write strobe |
| started_clr | input | 1 | Software clear of the started flag |
| start_pulse | output | 1 | One-cycle sequence launch |
| started | output | 1 | Sticky launch status |
| sw_pending | output | 1 | Software start bit readback, self-clearing |

## Verification
The bench sweeps every source with every hardware edge mode. For each pair it drives both a rising and a falling transition and pulses a neighbouring line. A wrong mode decode shows up as missing or extra pulses, and a wrong mux as pulses from the neighbour. Targeted cases check the following:
- the exact pulse latency through the synchroniser;
- a switch from a low source to a high source, where a design without blanking emits a false rising pulse;
- a high line at reset release;
- software requests made, or left pending, while hardware mode is on, which a wrong design would still fire;
- a start coinciding with a clear of the status flag, where the clear must not win.

// File: rtl/conv_trig_pkg.sv
package conv_trig_pkg;

  typedef enum logic [1:0] {
    TRIG_SW   = 2'd0,
    TRIG_RISE = 2'd1,
    TRIG_FALL = 2'd2,
    TRIG_BOTH = 2'd3
  } trig_mode_e;

  // Decide whether the transition prev -> cur is a start under mode m.
  function automatic logic edge_match(trig_mode_e m, logic prev, logic cur);
    logic hit;
    case (m)
      TRIG_RISE: hit = !prev && cur;
      TRIG_FALL: hit = prev && !cur;
      TRIG_BOTH: hit = prev ^ cur;
      default:   hit = 1'b0;
    endcase
    return hit;
  endfunction

  // Blanking length loaded into the settle counter.
  function automatic int settle_len(int stages, logic from_reset);
    return from_reset ? stages + 1 : stages;
  endfunction

endpackage

// File: rtl/trig_src_mux.sv
module trig_src_mux #(
  parameter int NUM_SRC = 16,
  parameter int SEL_W   = $clog2(NUM_SRC)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] trig_in,
  input  logic [SEL_W-1:0]   trig_sel,
  output logic               line_out,
  output logic               sel_changed
);

  logic [SEL_W-1:0] sel_q;
  logic [NUM_SRC-1:0] onehot;

  generate
    for (genvar i = 0; i < NUM_SRC; i++) begin : g_dec
      assign onehot[i] = (trig_sel == SEL_W'(i)) && trig_in[i];
    end
  endgenerate

  assign line_out    = |onehot;
  assign sel_changed = (trig_sel != sel_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sel_q <= '0;
    else        sel_q <= trig_sel;
  end

endmodule

// File: rtl/trig_edge_sync.sv
module trig_edge_sync
  import conv_trig_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       line_in,
  input  logic       restart,
  input  trig_mode_e mode,
  output logic       hw_hit,
  output logic       settle_busy
);

  localparam int CNT_W = $clog2(SYNC_STAGES + 2);
  localparam logic [CNT_W-1:0] LOAD_RST = CNT_W'(settle_len(SYNC_STAGES, 1'b1));
  localparam logic [CNT_W-1:0] LOAD_SEL = CNT_W'(settle_len(SYNC_STAGES, 1'b0));

  logic [SYNC_STAGES-1:0] chain;
  logic                   hist;
  logic [CNT_W-1:0]       settle;
  logic                   synced;

  generate
    for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_sync
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[0] <= 1'b0;
          else        chain[0] <= line_in;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[s] <= 1'b0;
          else        chain[s] <= chain[s-1];
        end
      end
    end
  endgenerate

  assign synced = chain[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist   <= 1'b0;
      settle <= LOAD_RST;
    end else begin
      hist <= synced;
      if (restart)            settle <= LOAD_SEL;
      else if (settle != '0)  settle <= settle - 1'b1;
    end
  end

  assign settle_busy = (settle != '0);
  assign hw_hit      = !settle_busy && edge_match(mode, hist, synced);

endmodule

// File: rtl/trig_start_ctrl.sv
module trig_start_ctrl
  import conv_trig_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  trig_mode_e mode,
  input  logic       hw_hit,
  input  logic       sw_start_set,
  input  logic       started_clr,
  output logic       sw_fire,
  output logic       start_pulse,
  output logic       started,
  output logic       sw_pending
);

  logic sw_mode;
  logic launch;

  assign sw_mode = (mode == TRIG_SW);
  assign sw_fire = sw_pending && sw_mode;
  assign launch  = hw_hit || sw_fire;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_pulse <= 1'b0;
      started     <= 1'b0;
      sw_pending  <= 1'b0;
    end else begin
      start_pulse <= launch;
      sw_pending  <= sw_start_set && sw_mode;
      if (launch)           started <= 1'b1;
      else if (started_clr) started <= 1'b0;
    end
  end

endmodule

// File: rtl/conv_trig_select.sv
module conv_trig_select
  import conv_trig_pkg::*;
#(
  parameter int NUM_SRC     = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [NUM_SRC-1:0]         trig_in,
  input  logic [$clog2(NUM_SRC)-1:0] trig_sel,
  input  logic [1:0]                 edge_mode,
  input  logic                       sw_start_set,
  input  logic                       started_clr,
  output logic                       start_pulse,
  output logic                       started,
  output logic                       sw_pending
);

  localparam int SEL_W = $clog2(NUM_SRC);

  trig_mode_e mode;
  logic       sel_line;
  logic       sel_changed;
  logic       hw_hit;
  logic       settle_busy;
  logic       sw_fire;

  assign mode = trig_mode_e'(edge_mode);

  trig_src_mux #(.NUM_SRC(NUM_SRC), .SEL_W(SEL_W)) u_mux (
    .clk         (clk),
    .rst_n       (rst_n),
    .trig_in     (trig_in),
    .trig_sel    (trig_sel),
    .line_out    (sel_line),
    .sel_changed (sel_changed)
  );

  trig_edge_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk         (clk),
    .rst_n       (rst_n),
    .line_in     (sel_line),
    .restart     (sel_changed),
    .mode        (mode),
    .hw_hit      (hw_hit),
    .settle_busy (settle_busy)
  );

  trig_start_ctrl u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .mode         (mode),
    .hw_hit       (hw_hit),
    .sw_start_set (sw_start_set),
    .started_clr  (started_clr),
    .sw_fire      (sw_fire),
    .start_pulse  (start_pulse),
    .started      (started),
    .sw_pending   (sw_pending)
  );

endmodule

// File: rtl/trig_sel_checker.sv
module trig_sel_checker (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] edge_mode,
  input logic       started_clr,
  input logic       start_pulse,
  input logic       started,
  input logic       sw_pending,
  input logic       hw_hit,
  input logic       settle_busy,
  input logic       sw_fire
);

  assert_sw_dropped_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_mode != 2'd0) |=> !sw_pending);

  assert_sw_fires_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_pending && edge_mode == 2'd0) |=> (start_pulse && !sw_pending));

  assert_no_hw_in_sw_mode_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_mode == 2'd0) |-> !hw_hit);

  assert_pulse_sets_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
    start_pulse |-> started);

  assert_flag_rise_has_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(started) |-> start_pulse);

  assert_flag_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (started_clr && !hw_hit && !sw_fire) |=> !started);

  assert_blank_no_hit_R8: assert property (@(posedge clk) disable iff (!rst_n)
    settle_busy |-> !hw_hit);

endmodule

bind conv_trig_select trig_sel_checker u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .edge_mode   (edge_mode),
  .started_clr (started_clr),
  .start_pulse (start_pulse),
  .started     (started),
  .sw_pending  (sw_pending),
  .hw_hit      (hw_hit),
  .settle_busy (settle_busy),
  .sw_fire     (sw_fire)
);

// File: tb/test_conv_trig_select.sv
`timescale 1ns/1ps
module test_conv_trig_select;

  localparam int NSRC = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] trig_in = '0;
  logic [3:0]  trig_sel = '0;
  logic [1:0]  edge_mode = '0;
  logic        sw_start_set = 1'b0;
  logic        started_clr = 1'b0;
  logic        start_pulse, started, sw_pending;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #2 clk = ~clk;

  conv_trig_select #(.NUM_SRC(NSRC), .SYNC_STAGES(2)) i_conv_trig_select (
    .clk(clk), .rst_n(rst_n), .trig_in(trig_in), .trig_sel(trig_sel),
    .edge_mode(edge_mode), .sw_start_set(sw_start_set), .started_clr(started_clr),
    .start_pulse(start_pulse), .started(started), .sw_pending(sw_pending)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic count_pulses(input int n, output int c);
    c = 0;
    repeat (n) begin
      @(posedge clk); #1;
      if (start_pulse) c++;
    end
  endtask

  task automatic clear_flag();
    @(negedge clk) started_clr = 1'b1;
    @(negedge clk) started_clr = 1'b0;
  endtask

  initial begin
    int c;
    int exp_r, exp_f;
    // R1: selected line already high across reset release
    trig_in[0] = 1'b1;
    edge_mode  = 2'd1;
    repeat (3) @(posedge clk);
    #1;
    chk("R1 pulse in reset", int'(start_pulse), 0);
    chk("R1 started in reset", int'(started), 0);
    chk("R1 pending in reset", int'(sw_pending), 0);
    @(negedge clk) rst_n = 1'b1;
    count_pulses(8, c);
    chk("R1 no pulse from high line at reset release", c, 0);
    @(negedge clk) trig_in = '0;
    count_pulses(6, c);
    chk("R4 falling ignored in rising mode", c, 0);

    // R4/R2: sweep every source and every hardware mode
    for (int s = 0; s < NSRC; s++) begin
      for (int m = 1; m < 4; m++) begin
        @(negedge clk);
        trig_in   = '0;
        trig_sel  = 4'(s);
        edge_mode = 2'(m);
        repeat (5) @(posedge clk);
        exp_r = (m == 1 || m == 3) ? 1 : 0;
        exp_f = (m == 2 || m == 3) ? 1 : 0;
        @(negedge clk) trig_in[s] = 1'b1;
        count_pulses(6, c);
        chk($sformatf("R4 rise src %0d mode %0d", s, m), c, exp_r);
        @(negedge clk) trig_in[s] = 1'b0;
        count_pulses(6, c);
        chk($sformatf("R4 fall src %0d mode %0d", s, m), c, exp_f);
        @(negedge clk) trig_in[(s + 1) % NSRC] = 1'b1;
        count_pulses(6, c);
        @(negedge clk) trig_in[(s + 1) % NSRC] = 1'b0;
        begin
          int c2;
          count_pulses(6, c2);
          chk($sformatf("R2 other line src %0d mode %0d", s, m), c + c2, 0);
        end
      end
    end

    // R6: exact latency, SYNC_STAGES = 2
    clear_flag();
    @(negedge clk);
    trig_sel = 4'd7; edge_mode = 2'd1; trig_in = '0;
    repeat (5) @(posedge clk);
    @(negedge clk) trig_in[7] = 1'b1;
    @(posedge clk);
    @(posedge clk); #1;
    chk("R6 no pulse after edge k+1", int'(start_pulse), 0);
    @(posedge clk); #1;
    chk("R6 pulse after edge k+2", int'(start_pulse), 1);
    chk("R7 started with pulse", int'(started), 1);
    @(posedge clk); #1;
    chk("R6 pulse lasts one cycle", int'(start_pulse), 0);
    clear_flag();
    #1;
    chk("R7 started cleared", int'(started), 0);

    // R8: switch from a low source to a high source
    @(negedge clk);
    trig_in = '0; trig_in[3] = 1'b1; trig_sel = 4'd5; edge_mode = 2'd3;
    repeat (6) @(posedge clk);
    @(negedge clk) trig_sel = 4'd3;
    count_pulses(8, c);
    chk("R8 no false edge on selector change", c, 0);
    @(negedge clk) trig_sel = 4'd5;
    count_pulses(8, c);
    chk("R8 no false edge switching back", c, 0);
    @(negedge clk) trig_in[5] = 1'b1;
    count_pulses(6, c);
    chk("R8 detection resumes after blanking", c, 1);

    // R5: mode 0 ignores hardware transitions
    @(negedge clk) begin edge_mode = 2'd0; trig_in = '0; end
    repeat (5) @(posedge clk);
    clear_flag();
    @(negedge clk) trig_in[5] = 1'b1;
    count_pulses(6, c);
    @(negedge clk) trig_in[5] = 1'b0;
    begin
      int c2;
      count_pulses(6, c2);
      chk("R5 hardware edges ignored in software mode", c + c2, 0);
    end
    #1;
    chk("R5 started untouched", int'(started), 0);

    // R3: software start timing
    @(negedge clk) sw_start_set = 1'b1;
    @(posedge clk); #1;
    chk("R3 pending after write", int'(sw_pending), 1);
    chk("R3 no pulse yet", int'(start_pulse), 0);
    @(negedge clk) sw_start_set = 1'b0;
    @(posedge clk); #1;
    chk("R3 pulse from software", int'(start_pulse), 1);
    chk("R3 pending self-cleared", int'(sw_pending), 0);
    chk("R7 started by software", int'(started), 1);
    @(posedge clk); #1;
    chk("R3 software pulse one cycle", int'(start_pulse), 0);

    // R7: start and clear in the same cycle, set wins
    @(negedge clk) sw_start_set = 1'b1;
    @(posedge clk);
    @(negedge clk) begin sw_start_set = 1'b0; started_clr = 1'b1; end
    @(posedge clk); #1;
    chk("R7 set wins over clear", int'(started), 1);
    @(negedge clk) started_clr = 1'b0;
    clear_flag();

    // R3: request while hardware mode is on is dropped
    @(negedge clk) begin edge_mode = 2'd1; sw_start_set = 1'b1; end
    @(posedge clk); #1;
    chk("R3 request not latched in hardware mode", int'(sw_pending), 0);
    @(negedge clk) sw_start_set = 1'b0;
    count_pulses(6, c);
    chk("R3 no pulse from request in hardware mode", c, 0);

    // R3: pending request dropped when mode leaves 0
    @(negedge clk) begin edge_mode = 2'd0; sw_start_set = 1'b1; end
    @(posedge clk);
    @(negedge clk) begin sw_start_set = 1'b0; edge_mode = 2'd2; end
    count_pulses(6, c);
    chk("R3 pending dropped on mode change", c, 0);
    #1;
    chk("R3 started stays clear", int'(started), 0);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule